// File: doc/BRIEF.md
# Rate-Sensor SPI Boot and Sample Sequencer

This block is an SPI master that brings up a digital rate sensor and then streams its samples to the host. Once reset is released it sends a fixed configuration script to the sensor, one byte per chip-select window. After the script it waits for the sensor's active-low ready line to fall. Each fall starts one read transaction: a read command byte, then two or three data bytes clocked in from the sensor.

The host sees the assembled sample, a single-cycle valid strobe and a busy flag. The serial side uses mode 3 (clock idles high; data is driven on the falling edge and sampled on the rising edge), eight bits per transfer, most significant bit first. Chip select rises after every byte and stays high for a programmable minimum time. The serial clock rate is set by a divider parameter.

Top module: `sensor_spi_seq`

## Requirements
- R1: The serial clock is high whenever chip select is high. It idles high, data changes on its falling edge and the sensor's output is sampled on its rising edge.
- R2: Every chip-select-low window carries exactly eight clock cycles, with the bits sent and received most significant first.
- R3: Between two bytes, chip select stays high for at least CS_GAP_SCLK x 2 x CLK_DIV system clock cycles.
- R4: After reset the block sends 0x01, 0x38, 0x03, 0x28, 0x0A, 0x30, 0x05, 0x2A, 0x0A, 0x32, 0x05, 0x38, 0x22 in that order, and then sends nothing until a ready fall.
- R5: A read sends the command 0x48 first, and then sends 0x00 on MOSI during each data byte.
- R6: With res16 low a read has three data bytes, and sample equals {byte1, byte2, byte3} (first byte in bits 23:16).
- R7: With res16 high (sampled when the read starts) a read has two data bytes, and sample equals {8'h00, byte1, byte2}.
- R8: Only a high-to-low transition of rdy_n, after a two-flop synchronizer, starts a read. Holding rdy_n low starts no further reads.
- R9: A ready fall that arrives during a read is held and serviced when that read ends. A further fall while one is already held is dropped.
- R10: sample_valid is high for exactly one cycle per read, in the cycle after the last data byte completes, and sample holds that read's value.
- R11: busy is high from reset through the end of the boot script and during every read. It is low while the block waits for ready, including the cycle of sample_valid.
- R12: During reset cs_n and sclk are high, and sample_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res16 | input | 1 | High selects two-byte samples |
| sample | output | 24 | Last assembled sample |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| busy | output | 1 | Boot or read in progress |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Sensor data in |
| cs_n | output | 1 | Active-low chip select |
| rdy_n | input | 1 | Active-low data-ready from sensor |

## Verification
The bench builds the block with CLK_DIV = 2 and CS_GAP_SCLK = 2. A byte then takes about 45 system cycles, so the whole boot script and many reads fit in a short run. The same setting also makes it easy to place a second and a third ready fall inside one read, which exercises the held-edge and dropped-edge paths. The minimum gap of 8 cycles is small enough to measure exactly between every pair of bytes.

// File: rtl/sensor_spi_pkg.sv
// Shared types and constants for the rate-sensor SPI sequencer.
// Assumes a single clock domain; the boot script is fixed at elaboration.
package sensor_spi_pkg;

    localparam int BOOT_LEN = 13;
    localparam int BOOT_IW  = 4;
    localparam logic [7:0] RD_CMD  = 8'h48;
    localparam logic [7:0] RD_FILL = 8'h00;

    typedef enum logic [1:0] {E_IDLE, E_LEAD, E_SHIFT, E_GAP} eng_state_e;
    typedef enum logic [1:0] {S_BOOT, S_WAIT, S_CMD, S_DATA} seq_state_e;

    // Configuration byte sent at position idx of the boot script.
    function automatic logic [7:0] boot_byte(input logic [BOOT_IW-1:0] idx);
        case (idx)
            4'd0:    boot_byte = 8'h01;
            4'd1:    boot_byte = 8'h38;
            4'd2:    boot_byte = 8'h03;
            4'd3:    boot_byte = 8'h28;
            4'd4:    boot_byte = 8'h0A;
            4'd5:    boot_byte = 8'h30;
            4'd6:    boot_byte = 8'h05;
            4'd7:    boot_byte = 8'h2A;
            4'd8:    boot_byte = 8'h0A;
            4'd9:    boot_byte = 8'h32;
            4'd10:   boot_byte = 8'h05;
            4'd11:   boot_byte = 8'h38;
            4'd12:   boot_byte = 8'h22;
            default: boot_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
// Mode-3 SPI byte transfer: pulls chip select low, shifts eight bits MSB
// first, raises chip select and holds it high for GAP_CYC cycles before
// pulsing done. Assumes start arrives only while idle.
module spi_byte_engine
    import sensor_spi_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int GAP_CYC = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       idle,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    input  logic       miso
);
    localparam int CMAX = (CLK_DIV > GAP_CYC) ? CLK_DIV : GAP_CYC;
    localparam int CW   = $clog2(CMAX + 1) + 1;
    localparam int GW   = $clog2(GAP_CYC + 2) + 1;

    eng_state_e    st;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    sreg;
    logic [7:0]    rx_q;

    assign idle    = (st == E_IDLE);
    assign rx_byte = rx_q;

    // Transfer state machine: lead-in, eight clock cycles, chip-select gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= E_IDLE;
            cnt     <= '0;
            bit_cnt <= '0;
            sreg    <= '0;
            rx_q    <= '0;
            sclk    <= 1'b1;
            cs_n    <= 1'b1;
            mosi    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (start) begin
                        cs_n    <= 1'b0;
                        sreg    <= tx_byte;
                        bit_cnt <= '0;
                        cnt     <= CW'(CLK_DIV - 1);
                        st      <= E_LEAD;
                    end
                end
                E_LEAD: begin
                    if (cnt == '0) begin
                        sclk <= 1'b0;
                        mosi <= sreg[7];
                        sreg <= {sreg[6:0], 1'b0};
                        cnt  <= CW'(CLK_DIV - 1);
                        st   <= E_SHIFT;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_SHIFT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!sclk) begin
                        sclk <= 1'b1;
                        rx_q <= {rx_q[6:0], miso};
                        cnt  <= CW'(CLK_DIV - 1);
                    end else if (bit_cnt == 3'd7) begin
                        cs_n <= 1'b1;
                        mosi <= 1'b1;
                        cnt  <= CW'(GAP_CYC - 1);
                        st   <= E_GAP;
                    end else begin
                        sclk    <= 1'b0;
                        mosi    <= sreg[7];
                        sreg    <= {sreg[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        cnt     <= CW'(CLK_DIV - 1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        done <= 1'b1;
                        st   <= E_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // Checker state: previous sclk, falling edges per window, cs-high run length.
    logic          chk_sclk_d;
    logic [3:0]    chk_edges;
    logic [GW-1:0] chk_gap;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_sclk_d <= 1'b1;
            chk_edges  <= '0;
            chk_gap    <= GW'(GAP_CYC);
        end else begin
            chk_sclk_d <= sclk;
            if (cs_n)
                chk_edges <= '0;
            else if (chk_sclk_d && !sclk)
                chk_edges <= chk_edges + 1'b1;
            if (!cs_n)
                chk_gap <= '0;
            else if (chk_gap < GW'(GAP_CYC))
                chk_gap <= chk_gap + 1'b1;
        end
    end

    p_sclk_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    p_eight_clocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (chk_edges == 4'd8));
    p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (chk_gap >= GW'(GAP_CYC)));
    p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == E_IDLE));

endmodule

// File: rtl/rdy_fall_latch.sv
// Synchronizes the active-low ready line with two flops and latches one
// falling edge as pending until the sequencer takes it. A fall seen while
// an edge is already pending is dropped.
module rdy_fall_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n,
    input  logic take,
    output logic pend
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic       fall;

    assign fall = prev_q && !sync_q[1];

    // Two-flop synchronizer plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], rdy_n};
            prev_q <= sync_q[1];
        end
    end

    // Pending flag: set by a fall, cleared when taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else
            pend <= (pend && !take) || fall;
    end

    p_pend_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !take) |=> pend);
    p_take_only_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend);

endmodule

// File: rtl/sensor_spi_seq.sv
// Top of the rate-sensor sequencer: runs the boot script once after reset,
// then turns each ready fall into a command byte plus two or three data
// bytes and presents the assembled sample. Assumes miso changes only on
// sclk falling edges, as a mode-3 slave does.
module sensor_spi_seq
    import sensor_spi_pkg::*;
#(
    parameter int CLK_DIV     = 8,
    parameter int CS_GAP_SCLK = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        res16,
    output logic [23:0] sample,
    output logic        sample_valid,
    output logic        busy,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    input  logic        rdy_n
);
    localparam int GAP_CYC = CS_GAP_SCLK * 2 * CLK_DIV;
    localparam logic [BOOT_IW-1:0] BOOT_LAST = BOOT_IW'(BOOT_LEN - 1);

    seq_state_e         st;
    logic [BOOT_IW-1:0] boot_idx;
    logic               inflight;
    logic               eng_start;
    logic [7:0]         eng_tx;
    logic               eng_idle;
    logic               eng_done;
    logic [7:0]         eng_rx;
    logic               mode16;
    logic [1:0]         data_idx;
    logic [15:0]        acc;
    logic               pend;
    logic               take;

    assign take = (st == S_WAIT) && pend;
    assign busy = (st != S_WAIT);

    rdy_fall_latch u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .rdy_n (rdy_n),
        .take  (take),
        .pend  (pend)
    );

    spi_byte_engine #(
        .CLK_DIV (CLK_DIV),
        .GAP_CYC (GAP_CYC)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .idle    (eng_idle),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sclk    (sclk),
        .mosi    (mosi),
        .cs_n    (cs_n),
        .miso    (miso)
    );

    // Sequencer: boot bytes, then command and data bytes per ready fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= S_BOOT;
            boot_idx     <= '0;
            inflight     <= 1'b0;
            eng_start    <= 1'b0;
            eng_tx       <= '0;
            mode16       <= 1'b0;
            data_idx     <= '0;
            acc          <= '0;
            sample       <= '0;
            sample_valid <= 1'b0;
        end else begin
            eng_start    <= 1'b0;
            sample_valid <= 1'b0;
            case (st)
                S_BOOT: begin
                    if (!inflight) begin
                        eng_start <= 1'b1;
                        eng_tx    <= boot_byte(boot_idx);
                        inflight  <= 1'b1;
                    end else if (eng_done) begin
                        inflight <= 1'b0;
                        if (boot_idx == BOOT_LAST)
                            st <= S_WAIT;
                        else
                            boot_idx <= boot_idx + 1'b1;
                    end
                end
                S_WAIT: begin
                    if (pend) begin
                        mode16 <= res16;
                        st     <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (!inflight) begin
                        eng_start <= 1'b1;
                        eng_tx    <= RD_CMD;
                        inflight  <= 1'b1;
                    end else if (eng_done) begin
                        inflight <= 1'b0;
                        data_idx <= '0;
                        st       <= S_DATA;
                    end
                end
                default: begin
                    if (!inflight) begin
                        eng_start <= 1'b1;
                        eng_tx    <= RD_FILL;
                        inflight  <= 1'b1;
                    end else if (eng_done) begin
                        inflight <= 1'b0;
                        acc      <= {acc[7:0], eng_rx};
                        if (data_idx == (mode16 ? 2'd1 : 2'd2)) begin
                            sample       <= mode16 ? {8'h00, acc[7:0], eng_rx}
                                                   : {acc, eng_rx};
                            sample_valid <= 1'b1;
                            st           <= S_WAIT;
                        end else begin
                            data_idx <= data_idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);
    p_valid_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> !busy);
    p_start_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);
    p_engine_quiet_waiting_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && !pend) |-> eng_idle);

endmodule

// File: tb/sensor_spi_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver pushes expected samples, a monitor compares
// them against sample_valid; a behavioural mode-3 slave answers reads.
module sensor_spi_seq_bench;
    localparam int CLK_DIV = 2;
    localparam int CS_GAP  = 2;
    localparam int GAP_CYC = CS_GAP * 2 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res16 = 1'b0;
    logic [23:0] sample;
    logic        sample_valid;
    logic        busy;
    logic        sclk, mosi, cs_n;
    logic        miso = 1'b1;
    logic        rdy_n = 1'b1;

    int checks = 0;
    int fails  = 0;
    int n_valid = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    sensor_spi_seq #(.CLK_DIV(CLK_DIV), .CS_GAP_SCLK(CS_GAP)) u_sensor_spi_seq (
        .clk(clk), .rst_n(rst_n), .res16(res16), .sample(sample),
        .sample_valid(sample_valid), .busy(busy), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .rdy_n(rdy_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic [7:0]  mlog[$];
    logic [23:0] slave_q[$];
    logic [23:0] cur_sample = '0;
    int          rd_left = 0;
    logic [7:0]  s_tx = 8'hFF, s_rx = '0;
    int          s_bits = 0;
    int          frame_bad = 0;

    always @(negedge cs_n) begin
        s_bits = 0;
        s_tx = (rd_left > 0) ? 8'(cur_sample >> (8 * (rd_left - 1))) : 8'hFF;
    end
    always @(negedge sclk) if (!cs_n) begin
        miso = s_tx[7];
        s_tx = {s_tx[6:0], 1'b1};
    end
    always @(posedge sclk) if (!cs_n) begin
        s_rx = {s_rx[6:0], mosi};
        s_bits++;
        if (s_bits == 8) begin
            mlog.push_back(s_rx);
            if (rd_left > 0) rd_left--;
            else if (s_rx == 8'h48) begin
                cur_sample = (slave_q.size() != 0) ? slave_q.pop_front() : 24'h0;
                rd_left = res16 ? 2 : 3;
            end
        end
    end
    always @(posedge cs_n) if (rst_n && s_bits != 8) frame_bad++;

    // ---------------- scoreboard monitor ----------------
    logic [23:0] exp_q[$];
    bit   prev_valid = 0;
    int   cs_hi_run = 0;
    int   gap_min = 1000000;
    bit   seen_low = 0;
    int   idle_bad = 0;

    always @(negedge clk) if (rst_n) begin
        if (sample_valid) begin
            n_valid++;
            if (exp_q.size() == 0)
                check(0, "R10 unexpected sample", int'(sample), 0);
            else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check(sample == e, "R6/R7 sample", int'(sample), int'(e));
            end
            check(!busy, "R11 busy low with valid", int'(busy), 0);
        end
        if (prev_valid && sample_valid)
            check(0, "R10 valid longer than one cycle", 1, 0);
        prev_valid = sample_valid;
        if (cs_n && !sclk) idle_bad++;
        if (cs_n) cs_hi_run++;
        else begin
            if (seen_low && cs_hi_run > 0 && cs_hi_run < gap_min) gap_min = cs_hi_run;
            if (cs_hi_run > 0) seen_low = 1;
            cs_hi_run = 0;
        end
    end

    // ---------------- driver ----------------
    task automatic pulse_rdy(input int low_cycles);
        @(negedge clk) rdy_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        rdy_n = 1'b1;
    endtask

    task automatic push_read(input logic [23:0] v, input bit m16);
        slave_q.push_back(v);
        exp_q.push_back(m16 ? {8'h00, v[15:0]} : v);
    endtask

    task automatic wait_drain();
        int t = 0;
        while ((exp_q.size() != 0 || busy) && t < 5000) begin
            @(negedge clk); t++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] boot_exp [13] = '{8'h01, 8'h38, 8'h03, 8'h28, 8'h0A, 8'h30, 8'h05,
                                     8'h2A, 8'h0A, 8'h32, 8'h05, 8'h38, 8'h22};
        int base, v0, t;
        repeat (4) @(negedge clk);
        // R12: reset state
        check(cs_n == 1 && sclk == 1, "R12 cs_n/sclk high in reset", {cs_n, sclk}, 3);
        check(sample_valid == 0, "R12 valid low in reset", sample_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1, "R11 busy during boot", busy, 1);
        t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        repeat (200) @(negedge clk);
        // R4: boot script
        check(mlog.size() == 13, "R4 boot byte count", mlog.size(), 13);
        for (int i = 0; i < 13 && i < mlog.size(); i++)
            check(mlog[i] == boot_exp[i], "R4 boot byte", mlog[i], boot_exp[i]);
        check(busy == 0, "R11 idle after boot", busy, 0);

        // R6: 24-bit reads with several patterns
        res16 = 0;
        push_read(24'hA5C31E, 0); pulse_rdy(10); wait_drain();
        base = mlog.size() - 4;
        check(mlog[base] == 8'h48, "R5 read command", mlog[base], 8'h48);
        for (int i = 1; i < 4; i++)
            check(mlog[base+i] == 8'h00, "R5 fill byte", mlog[base+i], 0);
        push_read(24'h800000, 0); pulse_rdy(10); wait_drain();
        push_read(24'h7FFFFF, 0); pulse_rdy(10); wait_drain();
        push_read(24'hFFFFFF, 0); pulse_rdy(10); wait_drain();

        // R7: 16-bit reads
        res16 = 1;
        base = mlog.size();
        push_read(24'h12BEEF, 1); pulse_rdy(10); wait_drain();
        check(mlog.size() - base == 3, "R7 byte count", mlog.size() - base, 3);
        check(mlog[base] == 8'h48, "R7 command", mlog[base], 8'h48);
        push_read(24'h008001, 1); pulse_rdy(10); wait_drain();

        // R8: a long low level starts only one read
        res16 = 0;
        v0 = n_valid;
        push_read(24'h135790, 0); pulse_rdy(600); wait_drain();
        repeat (300) @(negedge clk);
        check(n_valid - v0 == 1, "R8 one read per fall", n_valid - v0, 1);

        // R9: one held edge serviced, extra edge dropped
        v0 = n_valid;
        push_read(24'h2468AC, 0); push_read(24'hC0FFEE, 0);
        pulse_rdy(5);
        repeat (50) @(negedge clk);
        pulse_rdy(5);
        repeat (20) @(negedge clk);
        pulse_rdy(5);
        wait_drain();
        repeat (400) @(negedge clk);
        check(n_valid - v0 == 2, "R9 held edge kept, extra dropped", n_valid - v0, 2);
        check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

        // R1, R2, R3: serial framing over the whole run
        check(idle_bad == 0, "R1 sclk high while cs_n high", idle_bad, 0);
        check(frame_bad == 0, "R2 eight clocks per frame", frame_bad, 0);
        check(gap_min >= GAP_CYC, "R3 minimum cs_n high time", gap_min, GAP_CYC);
        finish_run();
    end

endmodule